// File: doc/BRIEF.md
# BiSS-C Frame Receiver

This block is the clock master for one BiSS-C encoder channel. A one-cycle trigger starts a frame. The block drives the encoder clock and ignores the line for a programmable number of oversample ticks, which covers the round-trip delay of cable and transceivers. It then looks for the acknowledge level and the start bit. After the start bit it shifts in a fixed-length field made of the control-data bit, the position word, the error and warning bits and a six-bit check value. It updates a CRC while the bits arrive.

After the last check bit the block enters the end-of-cycle timeout. It uses this phase to pass one control-data bit to the encoder through the shape of the clock: a steady high level sends a one, and a single low pulse sends a zero. When the timeout has run out, the captured fields and the CRC verdict are published together with a one-cycle done strobe.

The oversample ratio (8, or 4 for the fastest line rates), the tick divider and the delay compensation are taken from inputs at each trigger. The line rate can therefore be changed between frames at run time.

Top module: `biss_frame_rx`

## Requirements
- R1: After reset and while no frame is active, `enc_clk` is high and `done` is low.
- R2: A tick lasts `tick_div`+1 clock cycles. One encoder clock period lasts OSR ticks, where OSR is 4 when `osr4`=1 and 8 when `osr4`=0. The first half of each period is low, and the first period starts in the cycle after the trigger.
- R3: Ticks are counted from the start of the frame. Line bit n, counted from the first bit after `dly` ticks, is taken from the two-stage synchronized line at tick `dly` + n*OSR + OSR/2.
- R4: The receiver first waits for a sample equal to 0 (acknowledge) and then for a sample equal to 1 (start). The acknowledge level may last any number of bits.
- R5: After the start bit the receiver captures, in this order: the control-data bit (`cds_q`), the position word MSB first (`pos_q`), the error bit (`err_q`), the warning bit (`wrn_q`) and six check bits MSB first. Each output holds the raw line value.
- R6: The CRC uses the polynomial x^6+x+1, starts from zero and runs MSB first over the position, error and warning bits. The line carries the inverted CRC. `crc_ok` is 1 only when the received bits equal the bitwise complement of the computed value.
- R7: When the `cdm` level latched at trigger is 1, `enc_clk` stays high for the whole timeout.
- R8: When the latched `cdm` is 0, `enc_clk` makes exactly one low pulse of OSR/2 ticks at the start of the timeout.
- R9: The timeout lasts TOUT_TICKS ticks and starts right after the last check bit is sampled. In the cycle after the timeout, `done` pulses for one cycle and all result outputs update.
- R10: `osr4`, `tick_div`, `dly` and `cdm` are latched at the trigger. New values apply from the next frame on, and changes or triggers during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Frame start request, acted on only when idle |
| osr4 | input | 1 | 1 selects 4x oversampling, 0 selects 8x |
| tick_div | input | DIV_W | Tick length minus one, in clock cycles |
| dly | input | DLY_W | Delay compensation in ticks |
| cdm | input | 1 | Control-data level sent during the timeout |
| enc_clk | output | 1 | Clock to the encoder, idles high |
| enc_data | input | 1 | Serial data from the encoder |
| pos_q | output | POS_BITS | Captured position word |
| err_q | output | 1 | Captured error bit |
| wrn_q | output | 1 | Captured warning bit |
| cds_q | output | 1 | Captured control-data bit |
| crc_ok | output | 1 | CRC verdict for the last frame |
| done | output | 1 | One-cycle strobe when results are valid |

## Verification
The bench drives frames with acknowledge phases of different lengths. A receiver that demands exactly one acknowledge bit would slip by whole bits and return a shifted position word. The frames use different delays and tick lengths, so a receiver that ignores the delay or samples off the bit middle picks up neighbouring bits. One frame carries a corrupted check bit, which a receiver that forgets the inversion or uses the wrong polynomial flags wrongly. The bench counts the low clock cycles in the window just before `done`, which catches a missing or extra CDM pulse and a timeout of the wrong length. It also changes the configuration inputs and fires a trigger in the middle of a frame, which shows any receiver that fails to latch its settings.

// File: rtl/biss_rx_pkg.sv
package biss_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_START,
    ST_CAP,
    ST_TOUT
  } rx_state_t;

  // one step of the x^6+x+1 CRC, most significant bit first
  function automatic logic [5:0] crc6_next(input logic [5:0] c, input logic b);
    logic fb;
    fb = c[5] ^ b;
    return {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
  endfunction

  // oversample ticks per encoder clock period
  function automatic logic [3:0] osr_len(input logic sel4);
    return sel4 ? 4'd4 : 4'd8;
  endfunction

endpackage

// File: rtl/biss_tick_gen.sv
module biss_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

endmodule

// File: rtl/biss_line_sync.sv
module biss_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];

endmodule

// File: rtl/biss_crc6.sv
module biss_crc6
  import biss_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       bit_in,
  output logic [5:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc6_next(crc, bit_in);
  end

  // R6: clearing and accumulating never collide
  assert_clr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !en) else $error("crc clear during accumulate");

endmodule

// File: rtl/biss_frame_rx.sv
module biss_frame_rx
  import biss_rx_pkg::*;
#(
  parameter int POS_BITS   = 12,
  parameter int DIV_W      = 8,
  parameter int DLY_W      = 6,
  parameter int TOUT_TICKS = 32,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic                osr4,
  input  logic [DIV_W-1:0]    tick_div,
  input  logic [DLY_W-1:0]    dly,
  input  logic                cdm,
  output logic                enc_clk,
  input  logic                enc_data,
  output logic [POS_BITS-1:0] pos_q,
  output logic                err_q,
  output logic                wrn_q,
  output logic                cds_q,
  output logic                crc_ok,
  output logic                done
);
  localparam int CAP_BITS = POS_BITS + 9;
  localparam int CAPC_W   = $clog2(CAP_BITS);
  localparam int CRC_LO   = 1;
  localparam int CRC_HI   = POS_BITS + 2;

  rx_state_t            state;
  logic [CNT_W-1:0]     tcnt, nxt;
  logic [CAPC_W-1:0]    capcnt;
  logic [CAP_BITS-1:0]  shreg;
  logic                 osr_q, cdm_q;
  logic [DIV_W-1:0]     div_q;
  logic [5:0]           crc_acc;
  logic                 line_s, tick;

  // named internal events
  logic             busy, running, start_frame, sample_stb, last_bit, crc_en, frame_end;
  logic [CNT_W-1:0] osr_n, half_n, half_new;

  assign busy        = (state != ST_IDLE);
  assign running     = (state == ST_ACK) || (state == ST_START) || (state == ST_CAP);
  assign start_frame = trig && !busy;
  assign osr_n       = CNT_W'(osr_len(osr_q));
  assign half_n      = osr_n >> 1;
  assign half_new    = CNT_W'(osr_len(osr4)) >> 1;
  assign sample_stb  = running && tick && (tcnt == nxt);
  assign last_bit    = (state == ST_CAP) && (capcnt == CAPC_W'(CAP_BITS - 1));
  assign crc_en      = sample_stb && (state == ST_CAP) &&
                       (capcnt >= CAPC_W'(CRC_LO)) && (capcnt <= CAPC_W'(CRC_HI));
  assign frame_end   = (state == ST_TOUT) && tick && (tcnt == CNT_W'(TOUT_TICKS - 1));

  biss_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  biss_line_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(enc_data), .dout(line_s)
  );

  biss_crc6 crc_i (
    .clk(clk), .rst_n(rst_n), .clr(start_frame), .en(crc_en),
    .bit_in(line_s), .crc(crc_acc)
  );

  // encoder clock: idle high, running square wave, timeout override
  always_comb begin
    case (state)
      ST_IDLE: enc_clk = 1'b1;
      ST_TOUT: enc_clk = cdm_q ? 1'b1 : (tcnt >= half_n);
      default: enc_clk = osr_q ? tcnt[1] : tcnt[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tcnt   <= '0;
      nxt    <= '0;
      capcnt <= '0;
      shreg  <= '0;
      osr_q  <= 1'b0;
      cdm_q  <= 1'b1;
      div_q  <= '0;
      pos_q  <= '0;
      err_q  <= 1'b0;
      wrn_q  <= 1'b0;
      cds_q  <= 1'b0;
      crc_ok <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_frame) begin
        state  <= ST_ACK;
        tcnt   <= '0;
        nxt    <= CNT_W'(dly) + half_new;
        capcnt <= '0;
        osr_q  <= osr4;
        cdm_q  <= cdm;
        div_q  <= tick_div;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
        if (sample_stb) begin
          nxt <= nxt + osr_n;
          case (state)
            ST_ACK:   if (!line_s) state <= ST_START;
            ST_START: if (line_s)  state <= ST_CAP;
            ST_CAP: begin
              shreg  <= {shreg[CAP_BITS-2:0], line_s};
              capcnt <= capcnt + 1'b1;
              if (last_bit) begin
                state <= ST_TOUT;
                tcnt  <= '0;
              end
            end
            default: ;
          endcase
        end
        if (frame_end) begin
          state  <= ST_IDLE;
          done   <= 1'b1;
          cds_q  <= shreg[CAP_BITS-1];
          pos_q  <= shreg[CAP_BITS-2 -: POS_BITS];
          err_q  <= shreg[7];
          wrn_q  <= shreg[6];
          crc_ok <= (crc_acc == ~shreg[5:0]);
        end
      end
    end
  end

  // R2: a new frame always opens with the clock low
  assert_clk_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !enc_clk) else $error("frame did not open low");

  // R3: samples only fall on tick boundaries
  assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tick) else $error("sample off tick");

  // R7: no falling clock edge inside a timeout that carries a one
  assert_cdm_one_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(enc_clk) && state == ST_TOUT) |-> !cdm_q) else $error("clock fell with cdm=1");

  // R9: done is a single-cycle strobe that follows the timeout
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");

  assert_done_after_tout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == ST_TOUT)) else $error("done without timeout");

  // R10: settings stay frozen inside a frame
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(osr_q) && $stable(div_q) && $stable(cdm_q)))
    else $error("configuration changed mid-frame");

endmodule

// File: tb/biss_frame_rx_tb_top.sv
module biss_frame_rx_tb_top;
  localparam int POS = 12;
  localparam int TO  = 16;

  logic           clk = 1'b0, rst_n = 1'b0, trig = 1'b0, osr4 = 1'b0, cdm = 1'b1;
  logic           enc_data = 1'b1;
  logic [7:0]     tick_div = '0;
  logic [5:0]     dly = '0;
  logic           enc_clk, err_q, wrn_q, cds_q, crc_ok, done;
  logic [POS-1:0] pos_q;

  biss_frame_rx #(.POS_BITS(POS), .DIV_W(8), .DLY_W(6), .TOUT_TICKS(TO), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .osr4(osr4), .tick_div(tick_div), .dly(dly),
    .cdm(cdm), .enc_clk(enc_clk), .enc_data(enc_data), .pos_q(pos_q), .err_q(err_q),
    .wrn_q(wrn_q), .cds_q(cds_q), .crc_ok(crc_ok), .done(done)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [POS-1:0] pos;
    logic err, wrn, cds, ok, cdm;
    int lows, win;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, n_done = 0;

  // encoder model state
  logic fb [0:127];
  int   nb, eT = 1, eO = 8, eD = 0, ec = 0, tk, bi, lows;
  bit   armed = 0, enc_on = 0, clk_bad = 0, idle_bad = 0;
  logic ma_prev = 1'b1;
  bit   hist [2048];
  int   cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference CRC by polynomial division of msg*x^6 by x^6+x+1
  function automatic logic [5:0] crc_ref(logic [63:0] m, int len);
    logic [6:0] r = '0;
    for (int i = len - 1; i >= 0; i--) begin
      r = {r[5:0], m[i]};
      if (r[6]) r = r ^ 7'h43;
    end
    for (int i = 0; i < 6; i++) begin
      r = {r[5:0], 1'b0};
      if (r[6]) r = r ^ 7'h43;
    end
    return r[5:0];
  endfunction

  // encoder model, clock-shape probe and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !armed && !enc_on && !enc_clk) idle_bad = 1;
    if (armed && !enc_on && ma_prev && !enc_clk) begin
      enc_on = 1; ec = 0; clk_bad = 0;
    end
    if (enc_on) begin
      tk = ec / eT;
      if (ec < eO * eT && enc_clk !== (((tk % eO) >= eO / 2) ? 1'b1 : 1'b0)) clk_bad = 1;
      if (tk < eD) enc_data = 1'b1;
      else begin
        bi = (tk - eD) / eO;
        enc_data = (bi < nb) ? fb[bi] : 1'b0;
      end
      ec++;
    end
    if (done) begin
      exp_t e;
      n_done++;
      if (q.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
      else begin
        e = q.pop_front();
        chk({e.tag, " pos"}, 32'(pos_q), 32'(e.pos));
        chk("R5 err", 32'(err_q), 32'(e.err));
        chk("R5 wrn", 32'(wrn_q), 32'(e.wrn));
        chk("R5 cds", 32'(cds_q), 32'(e.cds));
        chk("R6 crc_ok", 32'(crc_ok), 32'(e.ok));
        lows = 0;
        for (int k = 1; k <= e.win; k++) lows += int'(hist[(cyc - k) % 2048]);
        chk(e.cdm ? "R7 timeout lows" : "R8 timeout lows", 32'(lows), 32'(e.lows));
        chk("R2 clock shape", 32'(clk_bad), 32'd0);
        chk("R9 clock high at done", 32'(enc_clk), 32'd1);
      end
      enc_on = 0; armed = 0; enc_data = 1'b1;
    end
    hist[cyc % 2048] = !enc_clk;
    cyc++;
    ma_prev = enc_clk;
  end

  task automatic frame(input logic [POS-1:0] pos, input logic err, input logic wrn,
                       input logic cds, input int ack, input bit bad, input logic o4,
                       input int div, input int d, input logic c_in, input string tag,
                       input bit busy_trig);
    logic [5:0] tx;
    int idx = 0, target;
    exp_t e;
    @(negedge clk);
    osr4 = o4; tick_div = 8'(div); dly = 6'(d); cdm = c_in;
    tx = ~crc_ref(64'({pos, err, wrn}), POS + 2);
    if (bad) tx[0] = ~tx[0];
    for (int i = 0; i < ack; i++) begin fb[idx] = 1'b0; idx++; end
    fb[idx] = 1'b1; idx++;
    fb[idx] = cds;  idx++;
    for (int i = POS - 1; i >= 0; i--) begin fb[idx] = pos[i]; idx++; end
    fb[idx] = err; idx++;
    fb[idx] = wrn; idx++;
    for (int i = 5; i >= 0; i--) begin fb[idx] = tx[i]; idx++; end
    nb = idx;
    eT = div + 1; eO = o4 ? 4 : 8; eD = d;
    e.pos = pos; e.err = err; e.wrn = wrn; e.cds = cds; e.ok = !bad; e.cdm = c_in;
    e.lows = c_in ? 0 : (eO / 2) * eT; e.win = TO * eT; e.tag = tag;
    q.push_back(e);
    target = n_done + 1;
    armed = 1; trig = 1;
    @(negedge clk);
    trig = 0;
    if (busy_trig) begin
      repeat (60) @(negedge clk);
      osr4 = !o4; tick_div = 8'(div + 3); cdm = !c_in; dly = 6'(d + 2);
      trig = 1;
      @(negedge clk);
      trig = 0;
    end
    while (n_done < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle clock", 32'(enc_clk), 32'd1);
    chk("R1 idle done", 32'(done), 32'd0);
    chk("R1 no clocking while idle", 32'(idle_bad), 32'd0);
    frame(12'hA5C, 1, 1, 0, 1, 0, 0, 3, 0, 1, "R5", 0);
    frame(12'h3F1, 0, 1, 1, 3, 0, 1, 2, 3, 0, "R10", 0);
    frame(12'h5A5, 1, 0, 0, 6, 0, 0, 1, 5, 0, "R4", 0);
    frame(12'h123, 1, 1, 1, 1, 1, 1, 3, 2, 1, "R6", 0);
    frame(12'hFFF, 0, 0, 1, 1, 0, 0, 2, 7, 1, "R3", 1);
    frame(12'h000, 1, 0, 0, 2, 0, 1, 1, 0, 0, "R9", 0);
    repeat (50) @(negedge clk);
    chk("R9 done count", 32'(n_done), 32'd6);
    chk("R1 idle after frames", 32'(enc_clk), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule